// File: doc/BRIEF.md
# Stereo Serial-Audio Receive Channel

This block is one stereo receive lane of a serial-audio controller. It watches a bit clock, a word-select line and a serial data line, rebuilds the left and right sample words, and stores each completed left/right pair in a small receive queue. A register bus lets software switch the lane on, choose the sample resolution, set a queue threshold, mask interrupts, clear a sticky overrun flag and empty the queue. Software drains samples by reading the left word and then the right word of the oldest pair.

The three serial inputs run slowly next to the system clock. They are synchronised into the system clock domain, and rising bit-clock edges are found there. Two interrupt outputs report that samples are waiting and that a pair was lost.

Top module: `i2sRxChannel`

## Requirements
- R1: A pair is captured only while the global enable (address 0, bit 0), the receive enable (address 1, bit 0) and the lane enable (address 2, bit 0) are all 1. If any of them is 0, the queue is left unchanged, and the capture state is cleared.
- R2: The resolution field (address 3, bits 2:0) sets the word length. Code 2 gives 16 bits, code 4 gives 24 bits, and code 5 or any other value gives 32 bits. A word holds the first N bits of its slot, first bit as MSB, right-aligned with zeros above.
- R3: Bits are sampled on the rising bit clock, MSB first, starting one bit after each word-select change. Word-select 0 is left. Capture starts at the first word-select change seen while enabled. A pair is stored when a left word and then a right word have been completed.
- R4: Reading address 8 returns the left word of the oldest pair. Reading address 9 returns its right word and removes the pair. With the queue empty, both reads return 0 and nothing is removed.
- R5: A pair completed while the queue holds DEPTH pairs is discarded and sets the overrun flag. The stored pairs are not changed.
- R6: Reading address 6 returns the overrun flag in bit 0 and clears it.
- R7: Writing address 7 with bit 0 = 1 empties the queue. A write with bit 0 = 0 has no effect.
- R8: irqRxAvail is high when the queue level is strictly greater than the threshold (address 4, 8 bits) and mask bit 0 (address 5) is 0. irqRxOverrun is the overrun flag gated by mask bit 1.
- R9: After reset, all configuration registers read 0, the queue is empty and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock |
| wordSel | input | 1 | Word select, 0 = left slot |
| serData | input | 1 | Serial sample data |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects happen on the clock edge) |
| regAddr | input | 4 | Register word address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| irqRxAvail | output | 1 | Samples-waiting interrupt |
| irqRxOverrun | output | 1 | Lost-pair interrupt |

## Verification
The assertions assume that the bit clock is much slower than the system clock, with each phase lasting at least three system cycles. They also assume that word-select and data are stable around every rising bit-clock edge. The overrun check also assumes that software does not rewrite the mask in the same cycle a pair is dropped. The stimulus holds each bit-clock phase for four system cycles and changes word-select and data only while the bit clock is low. It changes enables, resolution, threshold and mask only between bursts, while the bit clock is idle.

// File: rtl/i2sRxPkg.sv
package i2sRxPkg;
  localparam int CFG_W = 8;

  localparam logic [3:0] ADDR_GEN   = 4'd0;
  localparam logic [3:0] ADDR_RXEN  = 4'd1;
  localparam logic [3:0] ADDR_CHEN  = 4'd2;
  localparam logic [3:0] ADDR_RES   = 4'd3;
  localparam logic [3:0] ADDR_TRIG  = 4'd4;
  localparam logic [3:0] ADDR_MASK  = 4'd5;
  localparam logic [3:0] ADDR_OVR   = 4'd6;
  localparam logic [3:0] ADDR_FLUSH = 4'd7;
  localparam logic [3:0] ADDR_LEFT  = 4'd8;
  localparam logic [3:0] ADDR_RIGHT = 4'd9;

  // strobes from control to datapath
  typedef struct packed {
    logic       capEn;
    logic       flush;
    logic       pop;
    logic [2:0] resCode;
  } rxStrobeT;
endpackage

// File: rtl/i2sRxDatapath.sv
module i2sRxDatapath
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WORD  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(WORD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             wordSel,
  input  logic             serData,
  input  rxStrobeT         str,
  output logic [LVL_W-1:0] level,
  output logic [WORD-1:0]  headLeft,
  output logic [WORD-1:0]  headRight,
  output logic             dropEvt
);
  logic [2:0] clkSync;
  logic [1:0] wsSync, sdSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      wsSync  <= 2'b11;
      sdSync  <= '0;
    end else begin
      clkSync <= {clkSync[1:0], bitClk};
      wsSync  <= {wsSync[0], wordSel};
      sdSync  <= {sdSync[0], serData};
    end
  end

  logic bitEdge, wsNow, sdNow;
  assign bitEdge = clkSync[1] & ~clkSync[2];
  assign wsNow   = wsSync[1];
  assign sdNow   = sdSync[1];

  // word assembly
  logic [WORD-1:0]  shiftReg, shifted, leftHold;
  logic [CNT_W-1:0] bitCnt, resLen;
  logic             wsPrev, synced, leftValid, inBit, wsFlip, pairDone;

  always_comb begin
    case (str.resCode)
      3'd2:    resLen = CNT_W'(16);
      3'd4:    resLen = CNT_W'(24);
      default: resLen = CNT_W'(WORD);
    endcase
  end

  assign inBit    = bitCnt < resLen;
  assign shifted  = inBit ? {shiftReg[WORD-2:0], sdNow} : shiftReg;
  assign wsFlip   = wsNow != wsPrev;
  assign pairDone = str.capEn & bitEdge & wsFlip & synced & wsPrev & leftValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev    <= 1'b1;
      synced    <= 1'b0;
      leftValid <= 1'b0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      leftHold  <= '0;
    end else begin
      if (bitEdge) wsPrev <= wsNow;
      if (!str.capEn) begin
        synced    <= 1'b0;
        leftValid <= 1'b0;
        bitCnt    <= '0;
        shiftReg  <= '0;
      end else if (bitEdge) begin
        if (wsFlip) begin
          bitCnt   <= '0;
          shiftReg <= '0;
          synced   <= 1'b1;
          if (synced && !wsPrev) begin
            leftHold  <= shifted;
            leftValid <= 1'b1;
          end else if (synced) begin
            leftValid <= 1'b0;
          end
        end else begin
          shiftReg <= shifted;
          bitCnt   <= bitCnt + CNT_W'(inBit);
        end
      end
    end
  end

  // pair queue
  logic [2*WORD-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              full, push, pop;

  assign full    = level == LVL_W'(DEPTH);
  assign push    = pairDone & ~full & ~str.flush;
  assign dropEvt = pairDone & full;
  assign pop     = str.pop & (level != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {leftHold, shifted};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (str.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign headLeft  = mem[rdPtr][2*WORD-1:WORD];
  assign headRight = mem[rdPtr][WORD-1:0];
endmodule

// File: rtl/i2sRxCtrl.sv
module i2sRxCtrl
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WORD  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [CFG_W-1:0] regWrData,
  output logic [WORD-1:0]  regRdData,
  input  logic [LVL_W-1:0] level,
  input  logic [WORD-1:0]  headLeft,
  input  logic [WORD-1:0]  headRight,
  input  logic             dropEvt,
  output rxStrobeT         str,
  output logic             irqRxAvail,
  output logic             irqRxOverrun
);
  logic             gEn, rxEn, chEn, ovrFlag;
  logic [2:0]       resCode;
  logic [CFG_W-1:0] trigLvl;
  logic [1:0]       irqMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn     <= 1'b0;
      rxEn    <= 1'b0;
      chEn    <= 1'b0;
      resCode <= '0;
      trigLvl <= '0;
      irqMask <= '0;
      ovrFlag <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          ADDR_GEN:  gEn     <= regWrData[0];
          ADDR_RXEN: rxEn    <= regWrData[0];
          ADDR_CHEN: chEn    <= regWrData[0];
          ADDR_RES:  resCode <= regWrData[2:0];
          ADDR_TRIG: trigLvl <= regWrData;
          ADDR_MASK: irqMask <= regWrData[1:0];
          default: ;
        endcase
      end
      if (dropEvt) ovrFlag <= 1'b1;
      else if (regRdEn && regAddr == ADDR_OVR) ovrFlag <= 1'b0;
    end
  end

  logic qEmpty;
  assign qEmpty = level == '0;

  always_comb begin
    case (regAddr)
      ADDR_GEN:   regRdData = WORD'(gEn);
      ADDR_RXEN:  regRdData = WORD'(rxEn);
      ADDR_CHEN:  regRdData = WORD'(chEn);
      ADDR_RES:   regRdData = WORD'(resCode);
      ADDR_TRIG:  regRdData = WORD'(trigLvl);
      ADDR_MASK:  regRdData = WORD'(irqMask);
      ADDR_OVR:   regRdData = WORD'(ovrFlag);
      ADDR_LEFT:  regRdData = qEmpty ? '0 : headLeft;
      ADDR_RIGHT: regRdData = qEmpty ? '0 : headRight;
      default:    regRdData = '0;
    endcase
  end

  assign str.capEn   = gEn & rxEn & chEn;
  assign str.flush   = regWrEn & (regAddr == ADDR_FLUSH) & regWrData[0];
  assign str.pop     = regRdEn & (regAddr == ADDR_RIGHT);
  assign str.resCode = resCode;

  assign irqRxAvail   = (32'(level) > 32'(trigLvl)) & ~irqMask[0];
  assign irqRxOverrun = ovrFlag & ~irqMask[1];
endmodule

// File: rtl/i2sRxChannel.sv
module i2sRxChannel
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WORD  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             wordSel,
  input  logic             serData,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [CFG_W-1:0] regWrData,
  output logic [WORD-1:0]  regRdData,
  output logic             irqRxAvail,
  output logic             irqRxOverrun
);
  rxStrobeT         strobes;
  logic [LVL_W-1:0] fifoLevel;
  logic [WORD-1:0]  headLeft, headRight;
  logic             dropEvt;

  i2sRxCtrl #(.DEPTH(DEPTH), .WORD(WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .level(fifoLevel), .headLeft(headLeft), .headRight(headRight),
    .dropEvt(dropEvt), .str(strobes), .irqRxAvail(irqRxAvail),
    .irqRxOverrun(irqRxOverrun)
  );

  i2sRxDatapath #(.DEPTH(DEPTH), .WORD(WORD)) u_dp (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel),
    .serData(serData), .str(strobes), .level(fifoLevel),
    .headLeft(headLeft), .headRight(headRight), .dropEvt(dropEvt)
  );
endmodule

// File: rtl/i2sRxChecker.sv
module i2sRxChecker
  import i2sRxPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [3:0]       regAddr,
  input logic             flushBit,
  input logic [LVL_W-1:0] level,
  input logic             capEn,
  input logic             dropEvt,
  input logic [1:0]       irqMask,
  input logic             irqRxAvail,
  input logic             irqRxOverrun
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(level) <= DEPTH); // R5

  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (level > $past(level)) |-> $past(capEn)); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_FLUSH && flushBit) |=> (level == '0)); // R7

  AST_OVR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_OVR && !dropEvt) |=> !irqRxOverrun); // R6

  AST_DROP_RAISES_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (dropEvt && !irqMask[1] && !(regWrEn && regAddr == ADDR_MASK)) |=> irqRxOverrun); // R5

  AST_AVAIL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqMask[0] |-> !irqRxAvail); // R8
endmodule

bind i2sRxChannel i2sRxChecker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .flushBit(regWrData[0]), .level(fifoLevel),
  .capEn(strobes.capEn), .dropEvt(dropEvt), .irqMask(u_ctrl.irqMask),
  .irqRxAvail(irqRxAvail), .irqRxOverrun(irqRxOverrun)
);

// File: tb/tb_i2sRxChannel.sv
`timescale 1ns/1ps
module tb_i2sRxChannel;
  import i2sRxPkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, wordSel = 1'b1, serData = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqRxAvail, irqRxOverrun;

  always #2.5 clk = ~clk;

  i2sRxChannel #(.DEPTH(DEPTH), .WORD(32)) dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel),
    .serData(serData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqRxAvail(irqRxAvail), .irqRxOverrun(irqRxOverrun)
  );

  int checks = 0, errors = 0;
  // reference model
  logic [63:0] q[$];
  bit mEn = 0, mSynced = 0, mLv = 0, mOvr = 0, mMask0 = 0, mMask1 = 0;
  logic [31:0] mLeft;
  int resW = 32, trig = 0;
  logic curWs = 1'b1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  function automatic logic [31:0] trunc(logic [31:0] w);
    return w >> (32 - resW);
  endfunction

  task automatic modelTransition(logic prevCh, logic [31:0] w);
    if (!mEn) return;
    if (!mSynced) begin mSynced = 1; return; end
    if (prevCh == 1'b0) begin mLeft = trunc(w); mLv = 1; end
    else if (mLv) begin
      mLv = 0;
      if (q.size() == DEPTH) mOvr = 1;
      else q.push_back({mLeft, trunc(w)});
    end
  endtask

  task automatic sendBit(logic w, logic d);
    wordSel = w; serData = d; curWs = w; bitClk = 1'b0;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendSlot(logic ch, logic [31:0] d);
    for (int j = 0; j < 32; j++) sendBit((j == 31) ? ~ch : ch, d[31-j]);
    modelTransition(ch, d);
  endtask

  task automatic sendFrame(int n);
    if (curWs != 1'b0) begin
      sendBit(1'b0, 1'b0);
      modelTransition(1'b1, 32'h0);
    end
    sendSlot(1'b0, 32'h9E3779B9 * (n + 1));
    sendSlot(1'b1, 32'h7F4A7C15 * (n + 3) + 32'h1234);
  endtask

  task automatic setEn(bit g, bit r, bit c);
    regWrite(ADDR_GEN, {7'b0, g});
    regWrite(ADDR_RXEN, {7'b0, r});
    regWrite(ADDR_CHEN, {7'b0, c});
    mEn = g & r & c;
    if (!mEn) begin mSynced = 0; mLv = 0; end
  endtask

  task automatic setRes(logic [2:0] code);
    regWrite(ADDR_RES, {5'b0, code});
    resW = (code == 3'd2) ? 16 : (code == 3'd4) ? 24 : 32;
  endtask

  task automatic checkPair(string tag);
    logic [31:0] a, b;
    logic [63:0] e;
    e = (q.size() != 0) ? q[0] : 64'h0;
    regRead(ADDR_LEFT, a);
    check({tag, " left"}, a, e[63:32]);
    regRead(ADDR_RIGHT, b);
    check({tag, " right"}, b, e[31:0]);
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic checkIrqs(string tag);
    check({tag, " avail"}, {31'b0, irqRxAvail}, {31'b0, (q.size() > trig) && !mMask0});
    check({tag, " ovr"}, {31'b0, irqRxOverrun}, {31'b0, mOvr && !mMask1});
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    for (int a = 0; a < 10; a++) begin
      regRead(a[3:0], d);
      check($sformatf("R9 reg %0d", a), d, 32'h0);
    end
    checkIrqs("R9");

    // R1 no capture while any enable is off
    sendFrame(0); sendFrame(1);
    checkPair("R1 all off");
    setEn(1, 1, 0);
    sendFrame(2); sendFrame(3);
    checkPair("R1 lane off");
    checkIrqs("R1");
    setEn(0, 1, 1);
    sendFrame(4); sendFrame(5);
    checkPair("R1 global off");

    // R3 capture from first transition, 32-bit words
    setEn(1, 1, 1);
    setRes(3'd5);
    sendFrame(10); sendFrame(11); sendFrame(12);
    checkIrqs("R8 after R3 frames");
    checkPair("R3 pair a"); checkPair("R3 pair b");
    checkPair("R4 empty read");

    // R2 resolutions
    setRes(3'd2);
    sendFrame(20); sendFrame(21);
    checkPair("R2 16b a"); checkPair("R2 16b b");
    setRes(3'd4);
    sendFrame(22); sendFrame(23);
    checkPair("R2 24b a"); checkPair("R2 24b b");
    setRes(3'd7);
    sendFrame(24);
    checkPair("R2 code7 32b");

    // R8 threshold and mask
    regWrite(ADDR_TRIG, 8'd3); trig = 3;
    sendFrame(30); sendFrame(31); sendFrame(32);
    checkIrqs("R8 level equal trig");
    sendFrame(33);
    checkIrqs("R8 level above trig");
    regWrite(ADDR_MASK, 8'd1); mMask0 = 1;
    checkIrqs("R8 avail masked");
    regWrite(ADDR_MASK, 8'd0); mMask0 = 0;

    // R5 overrun on full queue
    for (int n = 40; n < 46; n++) sendFrame(n);
    checkIrqs("R5 overrun");
    regRead(ADDR_OVR, d);
    check("R6 ovr read", d, 32'h1);
    mOvr = 0;
    regRead(ADDR_OVR, d);
    check("R6 ovr cleared", d, 32'h0);
    checkIrqs("R6 irq");
    for (int k = 0; k < DEPTH; k++) checkPair($sformatf("R5 kept %0d", k));
    checkPair("R5 drained");

    // R8 overrun mask
    regWrite(ADDR_TRIG, 8'd0); trig = 0;
    regWrite(ADDR_MASK, 8'd2); mMask1 = 1;
    for (int n = 50; n < 59; n++) sendFrame(n);
    checkIrqs("R8 ovr masked");
    regRead(ADDR_OVR, d);
    check("R8 flag under mask", d, 32'h1);
    mOvr = 0;

    // R7 flush
    regWrite(ADDR_FLUSH, 8'h0);
    checkIrqs("R7 flush zero");
    checkPair("R7 after zero write");
    regWrite(ADDR_FLUSH, 8'h1);
    q.delete();
    checkIrqs("R7 flushed");
    checkPair("R7 empty after flush");
    sendFrame(60);
    checkPair("R7 capture after flush");

    finishRun();
  end
endmodule